// File: doc/BRIEF.md
# Pseudo-Random Bit Pattern Stimulus Source

This block produces a slow pseudo-random serial bit stream for driving a sluggish logic stage under test. Alongside the stream it produces a square trigger strobe at the bit rate, so an oscilloscope can lock to it. A 9-bit shift register with feedback advances once per bit period. The bit period is a fixed division of the reference clock. The low bits of the register are also presented in parallel.

The register shifts right. On each step, the bit leaving the low end is fed back in two ways: it is XORed into one interior position, and it is carried round into the top position. With the default mask this gives a maximal-length pattern of 511 bits. The strobe is low for the first half of every bit period and high for the second half. Its falling edge lines up with each new pattern value. An enable input freezes the whole block, and a synchronous reset re-seeds it.

Top module: `prbs_stim_gen`

## Requirements
- R1: While reset is high at a clock edge, the register loads the all-ones seed, the divider count goes to 0 and the strobe goes low. After reset, tap_o reads 5'h1F, pattern_o reads 1 and sync_o reads 0.
- R2: A step maps state s to {f, t[8:1]}, where f = s[0] and t = s XOR (f ? 9'h010 : 9'h000). tap_o carries s[4:0], and pattern_o equals tap_o[0].
- R3: The register steps on exactly every 48th enabled clock edge. The first step after reset release falls on the 48th enabled edge.
- R4: The register never holds all-zeros, so no window of 9 consecutive serial bits is all-zero. Should all-zeros ever occur, the next step reloads the seed.
- R5: The serial pattern repeats every 511 steps. All 511 cyclic 9-bit windows are distinct. After 511 steps tap_o is back at 5'h1F.
- R6: While en_i is low, the divider, the register and the strobe hold, and every output stays frozen.
- R7: Reset takes priority over enable. Raising rst_i with en_i high re-seeds the block on that edge.
- R8: sync_o goes low on each step edge. It rises on the enabled edge that takes the divider count from 23 to 24, so it is high for counts 24 through 47.
- R9: tap_o and pattern_o change only on step edges and hold on every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the block |
| pattern_o | output | 1 | Serial pseudo-random bit |
| tap_o | output | 5 | Low bits of the register state |
| sync_o | output | 1 | Bit-rate trigger strobe |

## Verification
The bench builds the block with its default parameters: a divide of 48, a 9-bit register with mask 9'h010, a 5-bit tap and the strobe rising at half period. At these values a full 511-step cycle takes about 25,000 clocks, so the bench can record every serial bit and test every 9-bit window for uniqueness and periodicity. It pauses enable partway through a bit period to check that the phase is held. It then re-seeds under reset with enable high and confirms that the first step falls on the 48th edge again.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
   // events raised by the divider for the current cycle
   typedef struct packed {
      logic step;  // last count of the bit period
      logic half;  // count just before the strobe rises
   } div_evt_t;
endpackage

// File: rtl/prbs_divider.sv
module prbs_divider
   import prbs_pkg::*;
#(
   parameter int DIV  = 48,
   parameter int RISE = 24,
   localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   output logic [CW-1:0] cnt_o,
   output div_evt_t      evt_o
);
   localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
   localparam logic [CW-1:0] PRE_HI = CW'(RISE - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         cnt_q <= '0;
      else if (en_i)
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   always_comb begin
      evt_o.step = en_i && (cnt_q == LAST);
      evt_o.half = en_i && (cnt_q == PRE_HI);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
   parameter int             W     = 9,
   parameter logic [W-1:0]   MASK  = 9'h010,
   parameter logic [W-1:0]   SEED  = '1,
   parameter bit             GUARD = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         step_i,
   output logic [W-1:0] state_o
);
   logic [W-1:0] q, t, shifted, nxt;
   logic         fb;

   always_comb begin
      fb      = q[0];
      t       = q ^ (fb ? MASK : '0);
      shifted = {fb, t[W-1:1]};
   end

   generate
      if (GUARD) begin : g_guard
         always_comb nxt = (q == '0) ? SEED : shifted;
      end else begin : g_plain
         always_comb nxt = shifted;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)
         q <= SEED;
      else if (step_i)
         q <= nxt;
   end

   assign state_o = q;
endmodule

// File: rtl/prbs_sync.sv
module prbs_sync
   import prbs_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_i,
   input  div_evt_t evt_i,
   output logic     sync_o
);
   logic q;

   always_ff @(posedge clk_i) begin
      if (rst_i)
         q <= 1'b0;
      else if (evt_i.step)
         q <= 1'b0;
      else if (evt_i.half)
         q <= 1'b1;
   end

   assign sync_o = q;
endmodule

// File: rtl/prbs_stim_gen.sv
module prbs_stim_gen
   import prbs_pkg::*;
#(
   parameter int                  DIV          = 48,
   parameter int                  LFSR_W       = 9,
   parameter logic [LFSR_W-1:0]   FB_MASK      = 9'h010,
   parameter logic [LFSR_W-1:0]   SEED         = '1,
   parameter int                  TAP_W        = 5,
   parameter int                  SYNC_AT      = DIV / 2,
   parameter bit                  LOCKUP_GUARD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   output logic             pattern_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             sync_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("prbs_stim_gen: DIV must be at least 2");
      end
      if (TAP_W < 1 || TAP_W > LFSR_W) begin : g_bad_tap
         $error("prbs_stim_gen: TAP_W must lie in 1..LFSR_W");
      end
      if (SYNC_AT < 1 || SYNC_AT > DIV - 1) begin : g_bad_sync
         $error("prbs_stim_gen: SYNC_AT must lie in 1..DIV-1");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("prbs_stim_gen: SEED must be non-zero");
      end
   endgenerate

   logic [CW-1:0]     div_cnt;
   div_evt_t          div_evt;
   logic              step_tick;
   logic [LFSR_W-1:0] lfsr_q;

   prbs_divider #(.DIV(DIV), .RISE(SYNC_AT)) u_div (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (en_i),
      .cnt_o (div_cnt),
      .evt_o (div_evt)
   );

   assign step_tick = div_evt.step;

   prbs_lfsr #(.W(LFSR_W), .MASK(FB_MASK), .SEED(SEED), .GUARD(LOCKUP_GUARD)) u_lfsr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .step_i  (step_tick),
      .state_o (lfsr_q)
   );

   prbs_sync u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .evt_i  (div_evt),
      .sync_o (sync_o)
   );

   assign tap_o     = lfsr_q[TAP_W-1:0];
   assign pattern_o = lfsr_q[0];
endmodule

// File: rtl/prbs_stim_chk.sv
module prbs_stim_chk #(
   parameter int           DIV     = 48,
   parameter int           SYNC_AT = 24,
   parameter int           W       = 9,
   parameter logic [W-1:0] SEED    = '1,
   parameter int           CW      = 6
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          en_i,
   input logic [CW-1:0] cnt,
   input logic          step,
   input logic [W-1:0]  state,
   input logic          sync
);
   p_seed_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (state == SEED && !sync && cnt == '0));

   p_step_at_last_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      step |-> (en_i && cnt == CW'(DIV - 1)));

   p_no_zero_state_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      state != '0);

   p_freeze_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(state) && $stable(cnt) && $stable(sync)));

   p_sync_low_on_step_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      step |=> !sync);

   p_sync_rise_point_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sync) |-> cnt == CW'(SYNC_AT));

   p_quiet_between_steps_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !step |=> $stable(state));
endmodule

bind prbs_stim_gen prbs_stim_chk #(
   .DIV(DIV), .SYNC_AT(SYNC_AT), .W(LFSR_W), .SEED(SEED), .CW(CW)
) u_chk (
   .clk_i (clk_i),
   .rst_i (rst_i),
   .en_i  (en_i),
   .cnt   (div_cnt),
   .step  (step_tick),
   .state (lfsr_q),
   .sync  (sync_o)
);

// File: tb/tb_prbs_stim_gen.sv
module tb_prbs_stim_gen;
   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 48;
   localparam int RISE = 24;
   localparam int PER  = 511;
   localparam int NLOG = 520;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       pattern;
   logic [4:0] tap;
   logic       sync;

   int n_cmp = 0;
   int n_bad = 0;
   int ph = 0;
   bit stepped = 1'b0;
   bit mon_on = 1'b0;
   logic [4:0] last_tap;
   logic [4:0] expq[$];
   logic [4:0] tap_log[$];
   bit         bit_log[$];

   prbs_stim_gen dut (
      .clk_i(clk), .rst_i(rst), .en_i(en),
      .pattern_o(pattern), .tap_o(tap), .sync_o(sync)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // model of the step rule given in R2
   function automatic logic [8:0] model_step(input logic [8:0] s);
      logic       f;
      logic [8:0] t;
      f = s[0];
      t = s ^ (f ? 9'h010 : 9'h000);
      return {f, t[8:1]};
   endfunction

   task automatic push_expected(input int n);
      logic [8:0] s = 9'h1FF;
      for (int i = 0; i < n; i++) begin
         s = model_step(s);
         expq.push_back(s[4:0]);
      end
   endtask

   // bench-side phase tracker (R3, R8)
   always @(posedge clk) begin
      if (rst) begin
         ph = 0;
         stepped = 1'b0;
      end else if (en) begin
         if (ph == DIV - 1) begin
            ph = 0;
            stepped = 1'b1;
         end else begin
            ph = ph + 1;
         end
      end
   end

   // monitor: pops expected items as steps occur
   always @(negedge clk) begin
      if (mon_on) begin
         check(sync == (ph >= RISE), "R8 sync phase", sync, ph >= RISE);
         if (stepped) begin
            stepped = 1'b0;
            if (expq.size() > 0) begin
               logic [4:0] e;
               e = expq.pop_front();
               check(tap == e, "R2/R3 tap after step", tap, e);
               check(pattern == e[0], "R2 serial bit", pattern, e[0]);
            end
            tap_log.push_back(tap);
            bit_log.push_back(pattern);
         end else begin
            check(tap == last_tap, "R9 tap held between steps", tap, last_tap);
         end
         last_tap = tap;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [4:0] held_tap;
      logic       held_sync;
      bit         seen[512];
      int         distinct;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(tap == 5'h1F, "R1 reset tap", tap, 5'h1F);
      check(pattern == 1'b1, "R1 reset serial", pattern, 1);
      check(sync == 1'b0, "R1 reset sync", sync, 0);
      last_tap = tap;
      push_expected(NLOG + 4);
      rst = 1'b0;
      en = 1'b1;
      mon_on = 1'b1;

      // run, then pause enable mid-period (R6)
      wait (tap_log.size() >= 200);
      @(negedge clk);
      while (ph != 10) @(negedge clk);
      en = 1'b0;
      held_tap = tap;
      held_sync = sync;
      repeat (37) @(negedge clk);
      check(tap == held_tap, "R6 tap frozen", tap, held_tap);
      check(sync == held_sync, "R6 sync frozen", sync, held_sync);
      en = 1'b1;

      wait (tap_log.size() >= NLOG);
      @(negedge clk);

      // R5: period and distinct windows; R4: no all-zero window
      check(tap_log[PER-1] == 5'h1F, "R5 seed after 511 steps", tap_log[PER-1], 5'h1F);
      for (int i = 0; i < 9; i++)
         check(bit_log[i] == bit_log[i+PER], "R5 serial period", bit_log[i+PER], bit_log[i]);
      distinct = 0;
      for (int i = 0; i < 512; i++) seen[i] = 1'b0;
      for (int i = 0; i < PER; i++) begin
         logic [8:0] w;
         for (int k = 0; k < 9; k++) w[k] = bit_log[i+k];
         if (!seen[w]) distinct++;
         seen[w] = 1'b1;
      end
      check(distinct == PER, "R5 distinct windows", distinct, PER);
      check(!seen[0], "R4 no all-zero window", seen[0], 0);

      // R7: reset with enable high, mid-period
      while (ph != 30) @(negedge clk);
      mon_on = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check(tap == 5'h1F, "R7 reseed tap", tap, 5'h1F);
      check(sync == 1'b0, "R7 reseed sync", sync, 0);
      repeat (4) @(negedge clk);
      check(pattern == 1'b1, "R7 reset holds over enable", pattern, 1);
      expq.delete();
      push_expected(3);
      rst = 1'b0;
      last_tap = tap;
      mon_on = 1'b1;
      repeat (DIV - 1) @(negedge clk);
      check(tap == 5'h1F, "R3 no step before 48th edge", tap, 5'h1F);
      repeat (2 * DIV + 5) @(negedge clk);
      check(expq.size() == 0, "R3 step count after reset", expq.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule